// File: doc/BRIEF.md
# PCI Single-Word Target Port

This block is the target side of a 32-bit PCI agent. It watches the bus for the start of a transaction. On the edge where the frame line first goes low, it captures the address from the shared address/data lines and the command from the command/byte-enable lines. It claims the transaction if the command is one it supports and the address falls in its window, or if IDSEL selects it for a configuration access. It then moves exactly one 32-bit word to or from a small register file. A claim runs on a fixed medium-decode schedule: device select first, target ready one clock later.

Four 32-bit registers sit in a 16-byte memory window. The window's base comes from a base-address register in configuration space. A mode input picks how bus byte lanes map onto register bytes, little- or big-endian, and the mapping applies to both writes and read data. The block drives parity for the read data it returns. It checks parity on every address phase and on write data, and a mismatch sets a sticky error flag. The surrounding pad logic merges the separate in/out/enable ports onto the bidirectional bus.

Top module: `pci_tgt_port`

## Requirements
- R1: After reset, devsel_n_o and trdy_n_o are high, ad_oe_o, par_oe_o and perr_o are low, and all memory registers and the base-address register read as zero.
- R2: Command 4'b0110 (memory read) or 4'b0111 (memory write) is claimed when AD[31:4] equals base-address bits 31:4. AD[3:2] selects one of the four registers.
- R3: Command 4'b1010 (configuration read) or 4'b1011 (configuration write) is claimed only when idsel_i is high and AD[1:0] is 2'b00. The dword index is AD[7:2]. Index 0 reads the constant DEV_ID, and index 4 (offset 0x10) is the base-address register, whose bits 3:0 always read zero. Every other index reads zero and ignores writes.
- R4: Any other command, an address outside the window, or a configuration access without idsel_i or with AD[1:0] nonzero leaves devsel_n_o high and changes no register.
- R5: For a claimed transaction whose address is sampled at edge E0, devsel_n_o goes low after edge E1 and trdy_n_o goes low after E2. The word moves on the first edge from E3 onward at which irdy_n_i is low, and both signals return high right after that edge.
- R6: On a write, only the bytes whose active-low enable bit is 0 are updated. The other bytes keep their value.
- R7: With big_endian_i low, bus lane i (bits 8i+7:8i, enabled by cbe_n_i[i]) corresponds to register byte i. With big_endian_i high, it corresponds to register byte 3-i. The same mapping applies to writes and to read data.
- R8: On a read, ad_oe_o is high and ad_o carries the mapped register value exactly while trdy_n_o is low.
- R9: par_oe_o is high on the clock after each clock in which read data is driven. par_o makes the count of ones even across par_o and the previous clock's ad_o and cbe_n_i.
- R10: For every address phase, par_i sampled one clock later is compared with the even parity of address and command. A mismatch sets perr_o.
- R11: For a claimed write, par_i sampled on the clock after the data transfer is compared with the even parity of the write data and byte enables. A mismatch sets perr_o. Parity on read data phases is not checked.
- R12: perr_o stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, all phases start on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_n_i | input | 1 | Active-low frame from the initiator |
| irdy_n_i | input | 1 | Active-low initiator ready |
| idsel_i | input | 1 | Configuration select |
| big_endian_i | input | 1 | Byte-lane mapping mode, 1 = big-endian |
| ad_i | input | 32 | Address/data bus as seen by the block |
| cbe_n_i | input | 4 | Command in address phase, active-low byte enables in data phase |
| par_i | input | 1 | Parity from the bus |
| ad_o | output | 32 | Read data to drive onto the bus |
| ad_oe_o | output | 1 | Output enable for ad_o |
| par_o | output | 1 | Parity for read data |
| par_oe_o | output | 1 | Output enable for par_o |
| devsel_n_o | output | 1 | Active-low device select |
| trdy_n_o | output | 1 | Active-low target ready |
| perr_o | output | 1 | Sticky parity error flag |

## Verification
The hardest case to reach from the ports is the write-data parity check. It compares par_i one clock after the transfer edge, and the transfer edge itself moves with the initiator's wait states. A parity fault therefore has to be placed on a clock that depends on how long irdy_n_i was held off. The bench's initiator drives data parity on every clock after the address-parity clock and varies the wait states from zero to three. This puts the bad parity clock at several distances from the claim. The reference model predicts the exact clock on which the sticky flag must rise. Read phases with corrupted parity and misses with corrupted data parity are also driven, to show that those leave the flag alone.

// File: rtl/pci_tgt_pkg.sv
package pci_tgt_pkg;

    localparam logic [3:0] CMD_MEM_RD = 4'b0110;
    localparam logic [3:0] CMD_MEM_WR = 4'b0111;
    localparam logic [3:0] CMD_CFG_RD = 4'b1010;
    localparam logic [3:0] CMD_CFG_WR = 4'b1011;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_DECODE = 2'd1,
        ST_CLAIM  = 2'd2,
        ST_DATA   = 2'd3
    } tgt_state_e;

    typedef struct packed {
        logic       hit;
        logic       is_wr;
        logic       is_cfg;
        logic [5:0] dw_idx;
    } xact_t;

endpackage

// File: rtl/pci_tgt_decode.sv
module pci_tgt_decode
    import pci_tgt_pkg::*;
#(
    parameter int WIN_LSB = 4
) (
    input  logic [31:0]          ad_i,
    input  logic [3:0]           cbe_n_i,
    input  logic                 idsel_i,
    input  logic [31-WIN_LSB:0]  bar_hi_i,
    output xact_t                xact_o
);

    logic mem_cmd;
    logic cfg_cmd;
    logic mem_hit;
    logic cfg_hit;

    always_comb begin
        mem_cmd = (cbe_n_i == CMD_MEM_RD) || (cbe_n_i == CMD_MEM_WR);
        cfg_cmd = (cbe_n_i == CMD_CFG_RD) || (cbe_n_i == CMD_CFG_WR);
        // R2: window compare on the bits above the register index
        mem_hit = mem_cmd && (ad_i[31:WIN_LSB] == bar_hi_i);
        // R3: type-0 configuration needs IDSEL and AD[1:0] == 00
        cfg_hit = cfg_cmd && idsel_i && (ad_i[1:0] == 2'b00);
        xact_o.hit    = mem_hit || cfg_hit;
        xact_o.is_wr  = cbe_n_i[0];
        xact_o.is_cfg = cfg_cmd;
        xact_o.dw_idx = ad_i[7:2];
    end

endmodule

// File: rtl/pci_tgt_lanes.sv
module pci_tgt_lanes #(
    parameter int NLANE = 4
) (
    input  logic                 big_i,
    input  logic [8*NLANE-1:0]   bus_wr_i,
    input  logic [NLANE-1:0]     be_n_i,
    input  logic [8*NLANE-1:0]   cur_i,
    output logic [8*NLANE-1:0]   merged_o,
    input  logic [8*NLANE-1:0]   rd_word_i,
    output logic [8*NLANE-1:0]   bus_rd_o
);

    // R7: lane k pairs with register byte k, or NLANE-1-k in big-endian mode
    for (genvar k = 0; k < NLANE; k++) begin : g_lane
        localparam int MIR = NLANE - 1 - k;
        logic       en_le;
        logic       en_be;
        logic [7:0] byte_new;

        always_comb begin
            en_le = !be_n_i[k];
            en_be = !be_n_i[MIR];
            if (big_i) begin
                byte_new = en_be ? bus_wr_i[8*MIR +: 8] : cur_i[8*k +: 8];
            end else begin
                byte_new = en_le ? bus_wr_i[8*k +: 8] : cur_i[8*k +: 8];
            end
            bus_rd_o[8*k +: 8] = big_i ? rd_word_i[8*MIR +: 8] : rd_word_i[8*k +: 8];
        end

        // R6: register byte k takes the bus only when its lane is enabled
        assign merged_o[8*k +: 8] = byte_new;
    end

endmodule

// File: rtl/pci_tgt_parity.sv
module pci_tgt_parity (
    input  logic        clk,
    input  logic        rst_n,
    input  logic [31:0] ad_i,
    input  logic [3:0]  cbe_n_i,
    input  logic        par_i,
    input  logic        chk_en_i,
    input  logic [31:0] drv_ad_i,
    input  logic        drv_en_i,
    output logic        par_o,
    output logic        par_oe_o,
    output logic        perr_o
);

    typedef struct packed {
        logic chk_pend;
        logic exp_par;
        logic par;
        logic par_oe;
        logic perr;
    } par_st_t;

    par_st_t par_q;
    par_st_t par_d;

    always_comb begin
        par_d          = par_q;
        // R10/R11: remember the parity owed for the phase on the bus now
        par_d.chk_pend = chk_en_i;
        par_d.exp_par  = ^{ad_i, cbe_n_i};
        // R9: parity lags the read data by one clock
        par_d.par      = ^{drv_ad_i, cbe_n_i};
        par_d.par_oe   = drv_en_i;
        // R12: sticky
        par_d.perr     = par_q.perr | (par_q.chk_pend && (par_i != par_q.exp_par));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            par_q <= '0;
        end else begin
            par_q <= par_d;
        end
    end

    assign par_o    = par_q.par;
    assign par_oe_o = par_q.par_oe;
    assign perr_o   = par_q.perr;

    p_perr_sticky_r12: assert property (@(posedge clk) disable iff (!rst_n)
        perr_o |=> perr_o);

endmodule

// File: rtl/pci_tgt_port.sv
module pci_tgt_port
    import pci_tgt_pkg::*;
#(
    parameter int          NREG   = 4,
    parameter logic [31:0] DEV_ID = 32'h1A2B_3C4D,
    parameter int          BAR_DW = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        frame_n_i,
    input  logic        irdy_n_i,
    input  logic        idsel_i,
    input  logic        big_endian_i,
    input  logic [31:0] ad_i,
    input  logic [3:0]  cbe_n_i,
    input  logic        par_i,
    output logic [31:0] ad_o,
    output logic        ad_oe_o,
    output logic        par_o,
    output logic        par_oe_o,
    output logic        devsel_n_o,
    output logic        trdy_n_o,
    output logic        perr_o
);

    localparam int IDX_W   = (NREG > 1) ? $clog2(NREG) : 1;
    localparam int WIN_LSB = IDX_W + 2;

    typedef struct packed {
        tgt_state_e               state;
        logic                     frame_prev;
        logic                     is_wr;
        logic                     is_cfg;
        logic [5:0]               idx;
        logic                     devsel_n;
        logic                     trdy_n;
        logic                     ad_oe;
        logic [31:0]              ad_o;
        logic [31:0]              bar;
        logic [NREG-1:0][31:0]    regs;
    } core_t;

    core_t q;
    core_t d;

    xact_t       dec;
    logic        addr_phase;
    logic        xfer;
    logic [31:0] rd_word;
    logic [31:0] bus_rd;
    logic [31:0] wr_cur;
    logic [31:0] wr_word;
    logic        chk_en;

    pci_tgt_decode #(.WIN_LSB(WIN_LSB)) i_decode (
        .ad_i     (ad_i),
        .cbe_n_i  (cbe_n_i),
        .idsel_i  (idsel_i),
        .bar_hi_i (q.bar[31:WIN_LSB]),
        .xact_o   (dec)
    );

    pci_tgt_lanes #(.NLANE(4)) i_lanes (
        .big_i     (big_endian_i),
        .bus_wr_i  (ad_i),
        .be_n_i    (cbe_n_i),
        .cur_i     (wr_cur),
        .merged_o  (wr_word),
        .rd_word_i (rd_word),
        .bus_rd_o  (bus_rd)
    );

    always_comb begin
        // R3: configuration space contents
        if (q.is_cfg) begin
            if (q.idx == 6'd0) begin
                rd_word = DEV_ID;
            end else if (q.idx == 6'(BAR_DW)) begin
                rd_word = q.bar;
            end else begin
                rd_word = '0;
            end
            wr_cur = q.bar;
        end else begin
            rd_word = q.regs[q.idx[IDX_W-1:0]];
            wr_cur  = q.regs[q.idx[IDX_W-1:0]];
        end
    end

    always_comb begin
        d          = q;
        d.frame_prev = frame_n_i;
        addr_phase = !frame_n_i && q.frame_prev;
        xfer       = (q.state == ST_DATA) && !irdy_n_i;
        chk_en     = addr_phase || (xfer && q.is_wr);

        case (q.state)
            ST_IDLE: begin
                if (addr_phase && dec.hit) begin
                    d.state  = ST_DECODE;
                    d.is_wr  = dec.is_wr;
                    d.is_cfg = dec.is_cfg;
                    d.idx    = dec.dw_idx;
                end
            end
            ST_DECODE: begin
                // R5: medium decode, claim one clock after capture
                d.state    = ST_CLAIM;
                d.devsel_n = 1'b0;
            end
            ST_CLAIM: begin
                d.state  = ST_DATA;
                d.trdy_n = 1'b0;
                // R8: read data goes out together with target ready
                d.ad_oe  = !q.is_wr;
                d.ad_o   = q.is_wr ? '0 : bus_rd;
            end
            ST_DATA: begin
                if (xfer) begin
                    d.state    = ST_IDLE;
                    d.devsel_n = 1'b1;
                    d.trdy_n   = 1'b1;
                    d.ad_oe    = 1'b0;
                    d.ad_o     = '0;
                    if (q.is_wr) begin
                        if (q.is_cfg) begin
                            if (q.idx == 6'(BAR_DW)) begin
                                d.bar = {wr_word[31:WIN_LSB], {WIN_LSB{1'b0}}};
                            end
                        end else begin
                            d.regs[q.idx[IDX_W-1:0]] = wr_word;
                        end
                    end
                end
            end
            default: d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q            <= '0;
            q.state      <= ST_IDLE;
            q.frame_prev <= 1'b1;
            q.devsel_n   <= 1'b1;
            q.trdy_n     <= 1'b1;
        end else begin
            q <= d;
        end
    end

    pci_tgt_parity i_parity (
        .clk      (clk),
        .rst_n    (rst_n),
        .ad_i     (ad_i),
        .cbe_n_i  (cbe_n_i),
        .par_i    (par_i),
        .chk_en_i (chk_en),
        .drv_ad_i (q.ad_o),
        .drv_en_i (q.ad_oe),
        .par_o    (par_o),
        .par_oe_o (par_oe_o),
        .perr_o   (perr_o)
    );

    assign ad_o       = q.ad_o;
    assign ad_oe_o    = q.ad_oe;
    assign devsel_n_o = q.devsel_n;
    assign trdy_n_o   = q.trdy_n;

    p_trdy_inside_devsel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n_o |-> !devsel_n_o);

    p_release_after_xfer_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!trdy_n_o && !irdy_n_i) |=> (devsel_n_o && trdy_n_o && !ad_oe_o));

    p_devsel_medium_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(devsel_n_o) |-> ($past(frame_n_i, 2) == 1'b0));

    p_ad_oe_window_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ad_oe_o |-> !trdy_n_o);

    p_par_even_r9: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe_o |-> ((^{$past(ad_o), $past(cbe_n_i)}) == par_o));

    p_par_follows_data_r9: assert property (@(posedge clk) disable iff (!rst_n)
        par_oe_o |-> $past(ad_oe_o));

endmodule

// File: tb/test_pci_tgt_port.sv
module test_pci_tgt_port;

    localparam logic [31:0] DEV_ID = 32'h1A2B_3C4D;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        idsel = 1'b0;
    logic        big = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        par = 1'b0;
    logic [31:0] ad_o;
    logic        ad_oe;
    logic        par_o;
    logic        par_oe;
    logic        devsel_n;
    logic        trdy_n;
    logic        perr;

    int n_chk = 0;
    int n_fail = 0;

    logic [31:0] m_regs [4];
    logic [31:0] m_bar;
    logic        m_perr;

    always #10 clk = ~clk;

    pci_tgt_port i_pci_tgt_port (
        .clk          (clk),
        .rst_n        (rst_n),
        .frame_n_i    (frame_n),
        .irdy_n_i     (irdy_n),
        .idsel_i      (idsel),
        .big_endian_i (big),
        .ad_i         (ad),
        .cbe_n_i      (cbe_n),
        .par_i        (par),
        .ad_o         (ad_o),
        .ad_oe_o      (ad_oe),
        .par_o        (par_o),
        .par_oe_o     (par_oe),
        .devsel_n_o   (devsel_n),
        .trdy_n_o     (trdy_n),
        .perr_o       (perr)
    );

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] swap_bytes(input logic [31:0] w, input bit be);
        return be ? {w[7:0], w[15:8], w[23:16], w[31:24]} : w;
    endfunction

    function automatic bit model_hit(input logic [3:0] cmd, input logic [31:0] addr, input bit sel);
        if (cmd == 4'b0110 || cmd == 4'b0111) return addr[31:4] == m_bar[31:4];
        if (cmd == 4'b1010 || cmd == 4'b1011) return sel && addr[1:0] == 2'b00;
        return 1'b0;
    endfunction

    function automatic logic [31:0] model_read(input bit cfg, input logic [31:0] addr);
        if (cfg) begin
            if (addr[7:2] == 6'd0) return DEV_ID;
            if (addr[7:2] == 6'd4) return m_bar;
            return '0;
        end
        return m_regs[addr[3:2]];
    endfunction

    task automatic model_write(input bit cfg, input logic [31:0] addr, input logic [31:0] wd,
                               input logic [3:0] be_n, input bit be);
        logic [31:0] cur;
        cur = cfg ? m_bar : m_regs[addr[3:2]];
        for (int i = 0; i < 4; i++) begin
            if (!be_n[i]) cur[8*(be ? 3-i : i) +: 8] = wd[8*i +: 8];
        end
        if (cfg) begin
            if (addr[7:2] == 6'd4) m_bar = {cur[31:4], 4'h0};
        end else begin
            m_regs[addr[3:2]] = cur;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0; frame_n = 1'b1; irdy_n = 1'b1; idsel = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < 4; i++) m_regs[i] = '0;
        m_bar = '0;
        m_perr = 1'b0;
        @(negedge clk);
        // R1: idle outputs after reset
        chk(devsel_n === 1'b1, "R1", "devsel_n", {31'd0, devsel_n}, 32'd1);
        chk(trdy_n === 1'b1, "R1", "trdy_n", {31'd0, trdy_n}, 32'd1);
        chk(ad_oe === 1'b0, "R1", "ad_oe", {31'd0, ad_oe}, 32'd0);
        chk(par_oe === 1'b0, "R1", "par_oe", {31'd0, par_oe}, 32'd0);
        chk(perr === 1'b0, "R1 R12", "perr cleared", {31'd0, perr}, 32'd0);
    endtask

    // One initiator transaction, compared against the model on every clock.
    task automatic xfer(input logic [3:0] cmd, input logic [31:0] addr, input bit sel,
                        input logic [31:0] wd, input logic [3:0] be_n, input bit be,
                        input int ws, input bit bad_ap, input bit bad_dp, input string rq);
        bit          hit;
        bit          wr;
        bit          cfg;
        bit          perr0;
        int          et;
        logic [31:0] rexp;
        bit          e_dl, e_tl, e_aoe, e_poe, e_perr;
        hit   = model_hit(cmd, addr, sel);
        wr    = cmd[0];
        cfg   = cmd[3];
        rexp  = swap_bytes(model_read(cfg, addr), be);
        perr0 = m_perr;
        et    = (1 + ws > 3) ? 1 + ws : 3;
        @(negedge clk);
        big = be; frame_n = 1'b0; irdy_n = 1'b1; ad = addr; cbe_n = cmd; idsel = sel;
        for (int n = 0; n <= et + 2; n++) begin
            @(negedge clk);
            e_dl   = hit && n >= 1 && n < et;
            e_tl   = hit && n >= 2 && n < et;
            e_aoe  = e_tl && !wr;
            e_poe  = hit && !wr && n >= 3 && n <= et;
            e_perr = perr0 | (bad_ap && n >= 1) | (hit && wr && bad_dp && n >= et + 1);
            // R5 schedule (claim decided per R2/R3/R4 given in rq)
            chk(devsel_n === !e_dl, rq, "devsel_n (R5)", {31'd0, devsel_n}, {31'd0, !e_dl});
            chk(trdy_n === !e_tl, rq, "trdy_n (R5)", {31'd0, trdy_n}, {31'd0, !e_tl});
            chk(ad_oe === e_aoe, "R8", "ad_oe", {31'd0, ad_oe}, {31'd0, e_aoe});
            if (e_aoe) chk(ad_o === rexp, rq, "read data (R8)", ad_o, rexp);
            chk(par_oe === e_poe, "R9", "par_oe", {31'd0, par_oe}, {31'd0, e_poe});
            if (e_poe) chk(par_o === ^{rexp, be_n}, "R9", "par_o", {31'd0, par_o}, {31'd0, ^{rexp, be_n}});
            chk(perr === e_perr, "R10/R11/R12", "perr", {31'd0, perr}, {31'd0, e_perr});
            // drive the next clock
            ad    = wr ? wd : 32'h0;
            cbe_n = be_n;
            idsel = 1'b0;
            par   = (n == 0) ? (^{addr, cmd} ^ bad_ap) : (^{wd & {32{wr}}, be_n} ^ bad_dp);
            irdy_n  = !((n + 1 >= 1 + ws) && (n + 1 <= et));
            frame_n = !(n + 1 < 1 + ws);
        end
        if (bad_ap) m_perr = 1'b1;
        if (hit && wr && bad_dp) m_perr = 1'b1;
        if (hit && wr) model_write(cfg, addr, wd, be_n, be);
    endtask

    initial begin : watchdog
        #(20 * 150000);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin : main
        logic [31:0] base;
        do_reset();
        // R1 / R3: initial contents
        xfer(4'b1010, 32'h0000_0000, 1, 0, 4'h0, 0, 0, 0, 0, "R3");
        xfer(4'b1010, 32'h0000_0010, 1, 0, 4'h0, 0, 1, 0, 0, "R1");
        xfer(4'b0110, 32'h0000_0004, 0, 0, 4'h0, 0, 2, 0, 0, "R1");
        // R3: base address programming, low bits forced to zero
        xfer(4'b1011, 32'h0000_0010, 1, 32'h8000_12F7, 4'h0, 0, 1, 0, 0, "R3");
        xfer(4'b1010, 32'h0000_0010, 1, 0, 4'h0, 0, 0, 0, 0, "R3");
        xfer(4'b1011, 32'h0000_0004, 1, 32'hDEAD_BEEF, 4'h0, 0, 0, 0, 0, "R3");
        xfer(4'b1010, 32'h0000_0004, 1, 0, 4'h0, 1, 0, 0, 0, "R3");
        base = m_bar;
        // R2: full-word writes and reads in both mappings
        for (int i = 0; i < 4; i++)
            xfer(4'b0111, base + 4*i, 0, 32'h1122_3344 + 32'h0101_0101*i, 4'h0, 0, i, 0, 0, "R2");
        for (int i = 0; i < 4; i++) begin
            xfer(4'b0110, base + 4*i, 0, 0, 4'h0, 0, 3-i, 0, 0, "R2");
            xfer(4'b0110, base + 4*i, 0, 0, 4'h0, 1, i, 0, 0, "R7");
        end
        // R6 / R7: partial lane writes
        xfer(4'b0111, base + 4, 0, 32'hA1B2_C3D4, 4'b1010, 0, 0, 0, 0, "R6");
        xfer(4'b0110, base + 4, 0, 0, 4'h0, 0, 0, 0, 0, "R6");
        xfer(4'b0111, base + 8, 0, 32'h5566_7788, 4'b0011, 1, 1, 0, 0, "R7");
        xfer(4'b0110, base + 8, 0, 0, 4'h0, 0, 0, 0, 0, "R7");
        xfer(4'b1011, 32'h0000_0010, 1, 32'h0000_0090, 4'b1110, 1, 0, 0, 0, "R7");
        base = m_bar;
        xfer(4'b1010, 32'h0000_0010, 1, 0, 4'h0, 0, 0, 0, 0, "R7");
        // R6 / R7: random traffic
        for (int k = 0; k < 40; k++) begin
            logic [3:0] rbe;
            rbe = 4'($urandom);
            xfer(($urandom % 2) ? 4'b0111 : 4'b0110, base + 4*($urandom % 4), 0,
                 $urandom, rbe, bit'($urandom % 2), int'($urandom % 4), 0, 0, "R6 R7");
        end
        // R4: transactions that must not be claimed
        xfer(4'b0111, base + 32'h10, 0, 32'hFFFF_FFFF, 4'h0, 0, 0, 0, 0, "R4");
        xfer(4'b0111, base ^ 32'h8000_0000, 0, 32'hFFFF_FFFF, 4'h0, 0, 1, 0, 0, "R4");
        xfer(4'b0011, base, 0, 32'hFFFF_FFFF, 4'h0, 0, 0, 0, 0, "R4");
        xfer(4'b0010, base, 0, 0, 4'h0, 0, 0, 0, 0, "R4");
        xfer(4'b1100, base, 0, 0, 4'h0, 0, 0, 0, 0, "R4");
        xfer(4'b1011, 32'h0000_0010, 0, 32'h0000_0F00, 4'h0, 0, 0, 0, 0, "R4");
        xfer(4'b1011, 32'h0000_0011, 1, 32'h0000_0F00, 4'h0, 0, 0, 0, 0, "R4");
        for (int i = 0; i < 4; i++) xfer(4'b0110, base + 4*i, 0, 0, 4'h0, 0, 0, 0, 0, "R4");
        xfer(4'b1010, 32'h0000_0010, 1, 0, 4'h0, 0, 0, 0, 0, "R4");
        // R11: bad parity on read data and on an unclaimed write is not flagged
        xfer(4'b0110, base, 0, 0, 4'h5, 0, 2, 0, 1, "R11");
        xfer(4'b0111, base + 32'h20, 0, 32'h1234_5678, 4'h0, 0, 1, 0, 1, "R11");
        // R10: bad address parity on a claimed read
        xfer(4'b0110, base + 4, 0, 0, 4'h0, 0, 0, 1, 0, "R10");
        // R12: stays set across clean traffic, cleared by reset
        xfer(4'b0111, base + 12, 0, 32'h0BAD_F00D, 4'h0, 0, 1, 0, 0, "R12");
        do_reset();
        // R10: address parity on a miss still counts
        xfer(4'b0010, 32'h0000_0100, 0, 0, 4'h0, 0, 0, 1, 0, "R10");
        do_reset();
        // R11: bad write-data parity with several wait-state counts
        for (int w = 0; w < 4; w++) begin
            xfer(4'b0111, 32'h0000_0000 + 4*w, 0, 32'hC0DE_0000 + w, 4'h0, w[0], w, 0, (w == 2), "R11");
        end
        xfer(4'b0110, 32'h0000_0008, 0, 0, 4'h0, 0, 0, 0, 0, "R12");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule